// File: doc/BRIEF.md
# Serial Output Update Engine with Control/Status Register

This block drives a chain of external shift registers that hold slot-control outputs: indicator LEDs, slot resets, slot enables, slot power enables and general-purpose outputs. It has one 8-bit control/status register. Software starts an update by writing 1 to the go bit while the engine is idle. At that moment the engine copies the current values of all parallel source buses into a snapshot. It then clocks the snapshot out on a serial data, serial clock and latch strobe interface.

The go bit reads back as the busy flag for the whole transfer. When the transfer ends, the go bit falls. If the completion interrupt enable is set at that point, a sticky pending flag is raised, and software clears it by writing 1 to it. The interrupt output combines this pending flag with an external general-interrupt pending input. The register also holds a write-1-to-clear flag that records arbitration timeouts, two scratch bits with no function, and a parallel-mode status bit that always reads 0.

Register bit positions: 0 go/busy, 1 completion pending (W1C), 2 completion interrupt enable, 3 arbitration-timeout flag (W1C), 4 general interrupt pending (read-only mirror of the input), 5 scratch A, 6 scratch B, 7 parallel-mode status (always 0).

Top module: `sout_ctrl_top`

## Requirements
- R1: A register write with bit 0 set while bit 0 reads 0 starts a transfer. Bit 0 reads 1 from the first cycle after that write.
- R2: A write with bit 0 clear, or with bit 0 set while a transfer is running, has no effect on the transfer. Its duration and its serial data stay unchanged.
- R3: Bit 0 returns to 0 exactly (2·N+2)·(clk_div+1) system cycles after the start write, where N is the total number of source bits (28 by default).
- R4: The serial stream is the snapshot {led, slot_rst, slot_en, slot_pwr, gpo} taken at the start write, sent MSB first. Each bit holds ser_clk low for clk_div+1 cycles and then high for clk_div+1 cycles, and ser_data is stable while ser_clk is high. Source changes after the start do not alter the stream.
- R5: After the last data bit, ser_latch is high for exactly 2·(clk_div+1) cycles, with ser_clk low. No ser_clk rising edge follows until the next transfer.
- R6: When bit 0 falls and bit 2 is 1, bit 1 is set. When bit 2 is 0, bit 1 is not set by the completion.
- R7: Writing 1 to bit 1 clears it, and writing 0 leaves it unchanged. If a clear and a completion that sets the bit happen in the same cycle, the bit ends set.
- R8: A one-cycle pulse on arb_to_evt sets bit 3. Writing 1 to bit 3 clears it, and writing 0 does not. A pulse coinciding with a clear leaves the bit set.
- R9: Bit 7 always reads 0. Bits 5 and 6 read back the values last written to them.
- R10: Bit 4 mirrors gen_irq_pend, and irq equals bit 1 OR gen_irq_pend.
- R11: After reset, all register bits read 0 and ser_data, ser_clk, ser_latch and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data |
| led_i | input | LED_W | Indicator LED source bits |
| slot_rst_i | input | RST_W | Slot reset source bits |
| slot_en_i | input | EN_W | Slot enable source bits |
| slot_pwr_i | input | PWR_W | Slot power enable source bits |
| gpo_i | input | GPO_W | General-purpose output source bits |
| clk_div | input | DIV_W | Serial half-period minus one, in system cycles |
| arb_to_evt | input | 1 | Arbitration timeout event pulse |
| gen_irq_pend | input | 1 | External general interrupt pending |
| ser_data | output | 1 | Serial data out |
| ser_clk | output | 1 | Serial shift clock |
| ser_latch | output | 1 | Latch strobe for the external registers |
| irq | output | 1 | Interrupt request |

## Verification
The bench changes every source bus right after the start write. An engine that reads the live buses instead of a snapshot would therefore shift out the wrong pattern. It writes go again, and writes go as 0, in the middle of a transfer. A design that restarts on either write would stretch the busy time or repeat bits. It times a pending clear so that it lands on the same edge as the completion, and does the same for an arbitration-timeout pulse. A design that lets the clear win would lose the event. Dividers from 0 to 15 check that the half-period, the latch width and the busy length scale together, which catches an off-by-one in the divider or the bit counter.

// File: rtl/sout_pkg.sv
package sout_pkg;
   typedef enum logic [1:0] {
      SO_IDLE  = 2'd0,
      SO_SHIFT = 2'd1,
      SO_LATCH = 2'd2
   } so_state_e;

   localparam int unsigned CSR_W    = 8;
   localparam int unsigned CSR_GO   = 0;
   localparam int unsigned CSR_PEND = 1;
   localparam int unsigned CSR_IE   = 2;
   localparam int unsigned CSR_ARB  = 3;
   localparam int unsigned CSR_GEN  = 4;
   localparam int unsigned CSR_SPA  = 5;
   localparam int unsigned CSR_SPB  = 6;
   localparam int unsigned CSR_PM   = 7;
endpackage

// File: rtl/sout_clkdiv.sv
module sout_clkdiv #(
   parameter int unsigned DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] div_q;

   assign tick = run && (cnt == div_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         div_q <= '0;
      end else if (load) begin
         cnt   <= '0;
         div_q <= div_i;
      end else if (run) begin
         cnt <= tick ? '0 : cnt + 1'b1;
      end
   end

   // R3: the half-period counter never runs past the captured divider
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= div_q));
endmodule

// File: rtl/sout_shifter.sv
module sout_shifter
   import sout_pkg::*;
#(
   parameter int unsigned NBITS = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NBITS-1:0] snap,
   input  logic             tick,
   output logic             load,
   output logic             busy,
   output logic             done,
   output logic             sdo,
   output logic             sclk,
   output logic             slatch
);
   localparam int unsigned CW = (NBITS > 1) ? $clog2(NBITS) : 1;

   so_state_e        state;
   logic [NBITS-1:0] sreg;
   logic [CW-1:0]    bcnt;
   logic             phase;

   assign load   = start && (state == SO_IDLE);
   assign busy   = (state != SO_IDLE);
   assign sdo    = (state == SO_SHIFT) && sreg[NBITS-1];
   assign sclk   = (state == SO_SHIFT) && phase;
   assign slatch = (state == SO_LATCH);
   assign done   = (state == SO_LATCH) && tick && phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SO_IDLE;
         sreg  <= '0;
         bcnt  <= '0;
         phase <= 1'b0;
      end else begin
         case (state)
            SO_IDLE: begin
               if (start) begin
                  sreg  <= snap;
                  bcnt  <= CW'(NBITS - 1);
                  phase <= 1'b0;
                  state <= SO_SHIFT;
               end
            end
            SO_SHIFT: begin
               if (tick) begin
                  if (!phase) begin
                     phase <= 1'b1;
                  end else begin
                     phase <= 1'b0;
                     if (bcnt == '0) begin
                        state <= SO_LATCH;
                     end else begin
                        sreg <= {sreg[NBITS-2:0], 1'b0};
                        bcnt <= bcnt - 1'b1;
                     end
                  end
               end
            end
            SO_LATCH: begin
               if (tick) begin
                  if (!phase) begin
                     phase <= 1'b1;
                  end else begin
                     phase <= 1'b0;
                     state <= SO_IDLE;
                  end
               end
            end
            default: state <= SO_IDLE;
         endcase
      end
   end

   // R1: an accepted start makes the engine busy on the next cycle
   p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy);
   // R2: once busy, only the completion ends the transfer
   p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   // R4: data is held while the serial clock is high
   p_sdo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(sdo));
   // R5: the strobe never overlaps a serial clock pulse
   p_latch_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      slatch |-> !sclk);
   // R11: idle interface is quiet
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(sclk || slatch || sdo));
endmodule

// File: rtl/sout_w1c_bank.sv
module sout_w1c_bank #(
   parameter int unsigned NF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set,
   input  logic [NF-1:0] clr,
   output logic [NF-1:0] flag
);
   for (genvar gi = 0; gi < NF; gi++) begin : g_flag
      logic q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q <= 1'b0;
         else if (set[gi]) q <= 1'b1;
         else if (clr[gi]) q <= 1'b0;
      end

      assign flag[gi] = q;

      // R7/R8: a set event is never lost to a simultaneous clear
      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
         set[gi] |=> q);
      // R7/R8: without a clear request the flag is sticky
      p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (q && !clr[gi]) |=> q);
   end
endmodule

// File: rtl/sout_ctrl_top.sv
module sout_ctrl_top
   import sout_pkg::*;
#(
   parameter int unsigned LED_W = 8,
   parameter int unsigned RST_W = 4,
   parameter int unsigned EN_W  = 4,
   parameter int unsigned PWR_W = 4,
   parameter int unsigned GPO_W = 8,
   parameter int unsigned DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csr_we,
   input  logic [7:0]       csr_wdata,
   output logic [7:0]       csr_rdata,
   input  logic [LED_W-1:0] led_i,
   input  logic [RST_W-1:0] slot_rst_i,
   input  logic [EN_W-1:0]  slot_en_i,
   input  logic [PWR_W-1:0] slot_pwr_i,
   input  logic [GPO_W-1:0] gpo_i,
   input  logic [DIV_W-1:0] clk_div,
   input  logic             arb_to_evt,
   input  logic             gen_irq_pend,
   output logic             ser_data,
   output logic             ser_clk,
   output logic             ser_latch,
   output logic             irq
);
   localparam int unsigned NBITS = LED_W + RST_W + EN_W + PWR_W + GPO_W;
   localparam int unsigned NF    = 2;
   localparam int unsigned F_PEND = 0;
   localparam int unsigned F_ARB  = 1;

   if (LED_W < 1 || RST_W < 1 || EN_W < 1 || PWR_W < 1 || GPO_W < 1) begin : g_bad_field
      $error("every source field needs at least one bit");
   end
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("DIV_W must be 1 to 16");
   end
   if (CSR_W != 8) begin : g_bad_csr
      $error("register width must be 8");
   end

   logic             start, load, busy, done, tick;
   logic             ie_q, spa_q, spb_q;
   logic [NF-1:0]    fset, fclr, flags;
   logic [NBITS-1:0] snap;
   logic             wdata_unused;

   assign wdata_unused = ^{csr_wdata[CSR_GEN], csr_wdata[CSR_PM]};
   assign snap  = {led_i, slot_rst_i, slot_en_i, slot_pwr_i, gpo_i};
   assign start = csr_we && csr_wdata[CSR_GO] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q  <= 1'b0;
         spa_q <= 1'b0;
         spb_q <= 1'b0;
      end else if (csr_we) begin
         ie_q  <= csr_wdata[CSR_IE];
         spa_q <= csr_wdata[CSR_SPA];
         spb_q <= csr_wdata[CSR_SPB];
      end
   end

   assign fset[F_PEND] = done && ie_q;
   assign fclr[F_PEND] = csr_we && csr_wdata[CSR_PEND];
   assign fset[F_ARB]  = arb_to_evt;
   assign fclr[F_ARB]  = csr_we && csr_wdata[CSR_ARB];

   sout_w1c_bank #(.NF(NF)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(fset), .clr(fclr), .flag(flags)
   );

   sout_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .load(load), .run(busy),
      .div_i(clk_div), .tick(tick)
   );

   sout_shifter #(.NBITS(NBITS)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .snap(snap), .tick(tick),
      .load(load), .busy(busy), .done(done),
      .sdo(ser_data), .sclk(ser_clk), .slatch(ser_latch)
   );

   always_comb begin
      csr_rdata           = '0;
      csr_rdata[CSR_GO]   = busy;
      csr_rdata[CSR_PEND] = flags[F_PEND];
      csr_rdata[CSR_IE]   = ie_q;
      csr_rdata[CSR_ARB]  = flags[F_ARB];
      csr_rdata[CSR_GEN]  = gen_irq_pend;
      csr_rdata[CSR_SPA]  = spa_q;
      csr_rdata[CSR_SPB]  = spb_q;
      csr_rdata[CSR_PM]   = 1'b0;
   end

   assign irq = flags[F_PEND] || gen_irq_pend;

   // R2: a go write during a transfer does not cut it short
   p_go_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_wdata[CSR_GO] && busy && !done) |=> csr_rdata[CSR_GO]);
   // R9: scratch bits hold the last written value
   p_scratch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      csr_we |=> (csr_rdata[CSR_SPA] == $past(csr_wdata[CSR_SPA])));
   // R6: a completion with the enable clear never raises the pending bit
   p_no_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr_rdata[CSR_PEND] && !(done && ie_q)) |=> !csr_rdata[CSR_PEND]);
endmodule

// File: tb/sim_sout_ctrl_top.sv
module sim_sout_ctrl_top;
   localparam int N = 28;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       csr_we = 1'b0;
   logic [7:0] csr_wdata = '0;
   logic [7:0] csr_rdata;
   logic [7:0] led_i = '0;
   logic [3:0] slot_rst_i = '0, slot_en_i = '0, slot_pwr_i = '0;
   logic [7:0] gpo_i = '0;
   logic [3:0] clk_div = '0;
   logic       arb_to_evt = 1'b0, gen_irq_pend = 1'b0;
   logic       ser_data, ser_clk, ser_latch, irq;

   int   n_chk = 0, n_bad = 0;
   logic scr_a = 1'b0, scr_b = 1'b0, exp_pend = 1'b0;

   always #2 clk = ~clk;

   sout_ctrl_top u0 (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .led_i(led_i), .slot_rst_i(slot_rst_i),
      .slot_en_i(slot_en_i), .slot_pwr_i(slot_pwr_i), .gpo_i(gpo_i),
      .clk_div(clk_div), .arb_to_evt(arb_to_evt), .gen_irq_pend(gen_irq_pend),
      .ser_data(ser_data), .ser_clk(ser_clk), .ser_latch(ser_latch), .irq(irq)
   );

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] ctl(bit go, bit pclr, bit ie, bit aclr);
      return {1'b0, scr_b, scr_a, 1'b0, aclr, ie, pclr, go};
   endfunction

   function automatic logic [63:0] exp_stream();
      return 64'({led_i, slot_rst_i, slot_en_i, slot_pwr_i, gpo_i});
   endfunction

   task automatic csr_wr(logic [7:0] d);
      @(negedge clk);
      csr_we = 1'b1;
      csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0;
      csr_wdata = '0;
   endtask

   task automatic randomize_src();
      led_i = 8'($urandom); slot_rst_i = 4'($urandom); slot_en_i = 4'($urandom);
      slot_pwr_i = 4'($urandom); gpo_i = 8'($urandom);
   endtask

   // poke: 0 none, 1 go again mid-run, 2 go=0 mid-run, 3 pending clear on completion edge
   task automatic xfer(int div, bit ie, int poke);
      logic [63:0] exp, cap;
      int busy_n, nb, lat, at_latch, total;
      logic prev, sclk_in_latch;
      randomize_src();
      clk_div = 4'(div);
      exp = exp_stream();
      total = (2 * N + 2) * (div + 1);
      @(negedge clk);
      csr_we = 1'b1;
      csr_wdata = ctl(1, 0, ie, 0);
      @(negedge clk);
      csr_we = 1'b0;
      randomize_src();
      chk("R1", "go reads busy after start", 64'(csr_rdata[0]), 64'd1);
      busy_n = 0; nb = 0; lat = 0; at_latch = -1; cap = '0; prev = 1'b0; sclk_in_latch = 1'b0;
      while (csr_rdata[0] === 1'b1 && busy_n < 5000) begin
         busy_n++;
         if (ser_clk && !prev) begin
            cap = {cap[62:0], ser_data};
            nb++;
         end
         if (ser_latch) begin
            lat++;
            if (at_latch < 0) at_latch = nb;
            if (ser_clk) sclk_in_latch = 1'b1;
         end
         prev = ser_clk;
         csr_we = 1'b0;
         if (poke == 1 && busy_n == 5) begin csr_we = 1'b1; csr_wdata = ctl(1, 0, ie, 0); end
         if (poke == 2 && busy_n == 5) begin csr_we = 1'b1; csr_wdata = ctl(0, 0, ie, 0); end
         if (poke == 3 && busy_n == total) begin csr_we = 1'b1; csr_wdata = ctl(0, 1, ie, 0); end
         @(negedge clk);
      end
      csr_we = 1'b0;
      exp_pend = (poke == 3) ? ie : (exp_pend | ie);
      chk(poke inside {1, 2} ? "R2" : "R3", "busy duration", 64'(busy_n), 64'(total));
      chk("R4", "bits shifted", 64'(nb), 64'(N));
      chk("R4", "serial pattern", cap & ((64'd1 << N) - 1), exp);
      chk("R5", "latch width", 64'(lat), 64'(2 * (div + 1)));
      chk("R5", "bits before latch", 64'(at_latch), 64'(N));
      chk("R5", "clock low during latch", 64'(sclk_in_latch), 64'd0);
      chk(poke == 3 ? "R7" : "R6", "pending after completion", 64'(csr_rdata[1]), 64'(exp_pend));
      chk("R10", "irq", 64'(irq), 64'(exp_pend | gen_irq_pend));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11", "register after reset", 64'(csr_rdata), 64'd0);
      chk("R11", "serial pins after reset", 64'({ser_data, ser_clk, ser_latch, irq}), 64'd0);

      // R9 scratch and parallel-mode bits
      scr_a = 1'b1; scr_b = 1'b1;
      csr_wr(8'hE0);
      chk("R9", "scratch bits set", 64'(csr_rdata[6:5]), 64'd3);
      chk("R9", "parallel-mode bit", 64'(csr_rdata[7]), 64'd0);
      chk("R2", "no start without go", 64'(csr_rdata[0]), 64'd0);
      scr_b = 1'b0;
      csr_wr(ctl(0, 0, 0, 0));
      chk("R9", "scratch bits update", 64'(csr_rdata[6:5]), 64'd1);

      // R10 general interrupt mirror
      gen_irq_pend = 1'b1;
      @(negedge clk);
      chk("R10", "gen mirror bit", 64'(csr_rdata[4]), 64'd1);
      chk("R10", "irq from gen input", 64'(irq), 64'd1);
      gen_irq_pend = 1'b0;
      @(negedge clk);
      chk("R10", "irq quiet", 64'(irq), 64'd0);

      // R8 arbitration timeout flag
      arb_to_evt = 1'b1;
      @(negedge clk);
      arb_to_evt = 1'b0;
      @(negedge clk);
      chk("R8", "arb flag set", 64'(csr_rdata[3]), 64'd1);
      csr_wr(ctl(0, 0, 0, 0));
      chk("R8", "arb write 0 keeps", 64'(csr_rdata[3]), 64'd1);
      csr_wr(ctl(0, 0, 0, 1));
      chk("R8", "arb write 1 clears", 64'(csr_rdata[3]), 64'd0);
      @(negedge clk);
      arb_to_evt = 1'b1;
      csr_we = 1'b1;
      csr_wdata = ctl(0, 0, 0, 1);
      @(negedge clk);
      arb_to_evt = 1'b0;
      csr_we = 1'b0;
      chk("R8", "set beats clear", 64'(csr_rdata[3]), 64'd1);
      csr_wr(ctl(0, 0, 0, 1));

      // R6 directed transfers
      xfer(0, 1'b0, 0);
      xfer(0, 1'b1, 0);
      // R7 write 0 keeps pending, write 1 clears it
      csr_wr(ctl(0, 0, 0, 0));
      chk("R7", "pending write 0 keeps", 64'(csr_rdata[1]), 64'd1);
      csr_wr(ctl(0, 1, 0, 0));
      exp_pend = 1'b0;
      chk("R7", "pending write 1 clears", 64'(csr_rdata[1]), 64'd0);
      xfer(15, 1'b1, 3);
      xfer(2, 1'b1, 1);
      xfer(1, 1'b0, 2);

      for (int i = 0; i < 20; i++) begin
         gen_irq_pend = 1'($urandom);
         xfer(int'($urandom_range(0, 3)), 1'($urandom), int'($urandom_range(0, 3)));
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule